// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the read path of a multi-bank flash device. While an embedded program or erase is running in one bank, it supplies the status word instead of array data for reads that fall in that bank. It also drives the ready/busy output. Reads that address any other bank, and all reads while no operation runs, pass the array data through unchanged.

The status word holds five flags. Bit 7 reports data polling: it is the inverted bit 7 of the programmed byte during a program, and 0 during an erase. Bit 6 flips on every status read. Bit 5 reports a timeout. Bit 3 marks an active erase. Bit 2 flips on every status read during an erase only. The top address bits select the bank. Read results are registered and appear one cycle after the read strobe.

The embedded algorithms, the array storage and the command decoder are outside this block. The command decoder supplies the operation start, its kind, the target bank and the programmed data. The algorithm supplies the completion pulse and the timeout flag. The array supplies the data for the read address.

Top module: `flash_op_status`

## Requirements
- R1: Every cycle with `rd_i` high is followed in the next cycle by `rd_valid_o` high, with `rd_data_o` holding that read's result. `rd_valid_o` is low in every other cycle.
- R2: For a status read during a program, bit 7 is the complement of bit 7 of `op_data_i` as captured at the start, and bit 3 is 0.
- R3: Bit 6 of the status word is 0 on the first status read after an accepted start. It inverts on each later status read, for both program and erase.
- R4: For a status read during an erase, bit 7 is 0 and bit 3 is 1.
- R5: Bit 5 is 0 until `timeout_i` is seen high in a cycle while an operation is running. From then on it reads 1 until the next accepted start.
- R6: Bit 2 reads 0 throughout a program. During an erase it is 0 on the first status read and inverts on each later status read.
- R7: `ready_o` is high after reset. It is low from the cycle after an accepted start until the operation completes.
- R8: A read whose bank field (the top `BANK_W` bits of `rd_addr_i`) differs from the running operation's bank, or any read while idle, returns `array_data_i` as sampled with the strobe.
- R9: One cycle after `op_done_i` is seen while busy, `ready_o` is high. Reads of the former busy bank then return array data.
- R10: `op_start_i` while an operation is running is ignored: the kind, bank and status of the running operation are unchanged.
- R11: In the status word, bits 4, 1 and 0 and all bits above 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Start pulse for an embedded operation, taken only when idle |
| op_erase_i | input | 1 | Operation kind with start: 1 erase, 0 program |
| op_bank_i | input | BANK_W | Bank the operation runs in |
| op_data_i | input | DATA_W | Data being programmed (bit 7 is captured) |
| op_done_i | input | 1 | Completion pulse from the embedded algorithm |
| timeout_i | input | 1 | Timing limit exceeded by the running operation |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Read address; top BANK_W bits select the bank |
| array_data_i | input | DATA_W | Array data for `rd_addr_i` |
| rd_data_o | output | DATA_W | Registered read result |
| rd_valid_o | output | 1 | Read result valid |
| ready_o | output | 1 | Ready (1) or busy (0) |

## Verification
The bench runs a program with bit 7 of the data set and another with it clear. Comparing the two shows that data polling follows the captured byte. An erase then separates the two toggle bits: bit 6 flips in both kinds, but bit 2 flips only in an erase. Interleaved reads to other banks and idle reads check that the bank compare gates status. Late timeouts, a start issued while busy, and reads right after completion check the sticky timeout, the refusal of a second start, and the return to array data.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned BIT_POLL  = 7;
  localparam int unsigned BIT_TGL   = 6;
  localparam int unsigned BIT_TMO   = 5;
  localparam int unsigned BIT_ERACT = 3;
  localparam int unsigned BIT_ETGL  = 2;

  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_kind_e;

  typedef struct packed {
    logic     busy;
    op_kind_e kind;
    logic     pgm_b7;
    logic     tmo;
  } op_state_t;
endpackage

// File: rtl/fsg_op_tracker.sv
module fsg_op_tracker
  import fsg_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              pgm_b7_i,
  input  logic              done_i,
  input  logic              timeout_i,
  output op_state_t         state_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              start_acc_o
);
  op_state_t         st_q;
  logic [BANK_W-1:0] bank_q;

  assign start_acc_o = start_i && !st_q.busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '{busy: 1'b0, kind: OP_PROG, pgm_b7: 1'b0, tmo: 1'b0};
      bank_q <= '0;
    end else if (start_acc_o) begin
      st_q.busy   <= 1'b1;
      st_q.kind   <= erase_i ? OP_ERASE : OP_PROG;
      st_q.pgm_b7 <= pgm_b7_i;
      st_q.tmo    <= 1'b0;
      bank_q      <= bank_i;
    end else if (st_q.busy) begin
      if (done_i)    st_q.busy <= 1'b0;
      if (timeout_i) st_q.tmo  <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign bank_o  = bank_q;

  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q.busy) |=> ($stable(bank_q) && $stable(st_q.kind))); // R10
  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.tmo && !start_acc_o) |=> st_q.tmo); // R5
endmodule

// File: rtl/fsg_toggle_unit.sv
module fsg_toggle_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic stat_rd_i,
  input  logic erase_i,
  output logic tgl_o,
  output logic etgl_o
);
  logic tgl_q, etgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q  <= 1'b0;
      etgl_q <= 1'b0;
    end else if (clear_i) begin
      tgl_q  <= 1'b0;
      etgl_q <= 1'b0;
    end else if (stat_rd_i) begin
      tgl_q <= ~tgl_q;
      if (erase_i) etgl_q <= ~etgl_q;
    end
  end

  assign tgl_o  = tgl_q;
  assign etgl_o = etgl_q;

  AST_TGL_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !clear_i) |=> (tgl_q != $past(tgl_q))); // R3
  AST_ETGL_STEADY_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !erase_i && !clear_i) |=> $stable(etgl_q)); // R6
endmodule

// File: rtl/fsg_read_mux.sv
module fsg_read_mux
  import fsg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  op_state_t         state_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              tgl_i,
  input  logic              etgl_i,
  output logic              stat_rd_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned BANK_LSB = ADDR_W - BANK_W;

  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, sel_q;
  logic              is_erase;

  assign is_erase  = (state_i.kind == OP_ERASE);
  assign stat_rd_o = rd_i && state_i.busy && (rd_addr_i[ADDR_W-1:BANK_LSB] == bank_i);

  always_comb begin
    stat_w            = '0;
    stat_w[BIT_POLL]  = is_erase ? 1'b0 : ~state_i.pgm_b7;
    stat_w[BIT_TGL]   = tgl_i;
    stat_w[BIT_TMO]   = state_i.tmo;
    stat_w[BIT_ERACT] = is_erase;
    stat_w[BIT_ETGL]  = is_erase & etgl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      valid_q <= rd_i;
      if (rd_i) begin
        data_q <= stat_rd_o ? stat_w : array_data_i;
        sel_q  <= stat_rd_o;
      end
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o); // R1
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && sel_q) |-> (rd_data_o[4] == 1'b0 && rd_data_o[1:0] == 2'b00)); // R11
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import fsg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic [BANK_W-1:0] op_bank_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              op_done_i,
  input  logic              timeout_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              ready_o
);
  op_state_t         st;
  logic [BANK_W-1:0] bank;
  logic              start_acc, stat_rd, tgl, etgl;

  fsg_op_tracker #(.BANK_W(BANK_W)) u_trk (
    .clk_i, .rst_ni,
    .start_i    (op_start_i),
    .erase_i    (op_erase_i),
    .bank_i     (op_bank_i),
    .pgm_b7_i   (op_data_i[7]),
    .done_i     (op_done_i),
    .timeout_i  (timeout_i),
    .state_o    (st),
    .bank_o     (bank),
    .start_acc_o(start_acc)
  );

  fsg_toggle_unit u_tgl (
    .clk_i, .rst_ni,
    .clear_i  (start_acc),
    .stat_rd_i(stat_rd),
    .erase_i  (st.kind == OP_ERASE),
    .tgl_o    (tgl),
    .etgl_o   (etgl)
  );

  fsg_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
    .clk_i, .rst_ni,
    .rd_i, .rd_addr_i, .array_data_i,
    .state_i  (st),
    .bank_i   (bank),
    .tgl_i    (tgl),
    .etgl_i   (etgl),
    .stat_rd_o(stat_rd),
    .rd_data_o, .rd_valid_o
  );

  assign ready_o = !st.busy;

  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_i && ready_o) |=> !ready_o); // R7
  AST_READY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !ready_o) |=> ready_o); // R9
endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;
  localparam int DATA_W = 8, ADDR_W = 12, BANK_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, op_done = 0, timeout = 0, rd = 0;
  logic [BANK_W-1:0] op_bank = '0;
  logic [DATA_W-1:0] op_data = '0, array_data, rd_data;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic rd_valid, ready;

  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign array_data = rd_addr[7:0] ^ 8'h3C;

  flash_op_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .op_erase_i(op_erase),
    .op_bank_i(op_bank), .op_data_i(op_data), .op_done_i(op_done), .timeout_i(timeout),
    .rd_i(rd), .rd_addr_i(rd_addr), .array_data_i(array_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .ready_o(ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  bit m_busy = 0, m_erase = 0, m_b7 = 0, m_to = 0, m_t6 = 0, m_t2 = 0;
  int m_bank = 0;
  bit e_valid = 0, e_stat = 0, e_erase = 0;
  int e_data = 0;
  bit model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_erase = 0; m_b7 = 0; m_to = 0; m_t6 = 0; m_t2 = 0; m_bank = 0;
      e_valid = 0; e_stat = 0; e_data = 0;
    end else begin
      e_valid = rd;
      if (rd) begin
        e_stat = m_busy && (int'(rd_addr[ADDR_W-1 -: BANK_W]) == m_bank);
        e_erase = m_erase;
        if (e_stat) begin
          e_data = 0;
          if (!m_erase && !m_b7) e_data += 128;
          if (m_t6) e_data += 64;
          if (m_to) e_data += 32;
          if (m_erase) e_data += 8;
          if (m_erase && m_t2) e_data += 4;
          m_t6 = !m_t6;
          if (m_erase) m_t2 = !m_t2;
        end else e_data = int'(array_data);
      end
      if (op_start && !m_busy) begin
        m_busy = 1; m_erase = op_erase; m_bank = int'(op_bank); m_b7 = op_data[7];
        m_to = 0; m_t6 = 0; m_t2 = 0;
      end else if (m_busy) begin
        if (timeout) m_to = 1;
        if (op_done) m_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(rd_valid == e_valid, "R1", rd_valid, e_valid);
      chk(ready == !m_busy, "R7", ready, !m_busy);
      if (e_valid && !e_stat) chk(int'(rd_data) == e_data, "R8", rd_data, e_data);
      if (e_valid && e_stat) begin
        chk(rd_data[7] == e_data[7], e_erase ? "R4" : "R2", rd_data[7], e_data[7]);
        chk(rd_data[3] == e_data[3], e_erase ? "R4" : "R2", rd_data[3], e_data[3]);
        chk(rd_data[6] == e_data[6], "R3", rd_data[6], e_data[6]);
        chk(rd_data[5] == e_data[5], "R5", rd_data[5], e_data[5]);
        chk(rd_data[2] == e_data[2], "R6", rd_data[2], e_data[2]);
        chk({rd_data[4], rd_data[1:0]} == 3'b000, "R11", {rd_data[4], rd_data[1:0]}, 0);
      end
    end
  end

  task automatic read(input int bank, input int off);
    rd = 1; rd_addr = ADDR_W'((bank << (ADDR_W - BANK_W)) | off);
    @(negedge clk); rd = 0;
  endtask

  task automatic start(input bit er, input int bank, input int data);
    op_start = 1; op_erase = er; op_bank = BANK_W'(bank); op_data = DATA_W'(data);
    @(negedge clk); op_start = 0;
  endtask

  task automatic finish_op();
    op_done = 1; @(negedge clk); op_done = 0;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 1'b1 && rd_valid == 1'b0, "R7", {ready, rd_valid}, 2);
    model_on = 1;
    // idle reads
    for (int i = 0; i < 4; i++) read(i, 16 * i + 3);
    // program, data bit7 = 1
    start(0, 1, 8'hA7);
    for (int i = 0; i < 5; i++) read(1, i);
    read(2, 5); read(1, 9);
    @(negedge clk);
    timeout = 1; @(negedge clk); timeout = 0;
    read(1, 1); read(1, 2);
    // ignored start while busy
    start(1, 2, 8'h00);
    read(1, 3);
    chk(rd_data[3] == 1'b0 && rd_data[7] == 1'b0, "R10", rd_data, 8'h00);
    read(2, 4);
    finish_op();
    chk(ready == 1'b1, "R9", ready, 1);
    read(1, 7);
    chk(rd_data == (8'h07 ^ 8'h3C), "R9", rd_data, 8'h07 ^ 8'h3C);
    // program, data bit7 = 0
    start(0, 0, 8'h15);
    for (int i = 0; i < 3; i++) read(0, i);
    finish_op();
    // erase in bank 3
    start(1, 3, 0);
    for (int i = 0; i < 6; i++) begin
      read(3, i);
      if (i == 2) read(0, 8);
    end
    timeout = 1; @(negedge clk); timeout = 0;
    for (int i = 0; i < 3; i++) read(3, i);
    // done and read on the same edge: the read still sees status
    op_done = 1; rd = 1; rd_addr = ADDR_W'(3 << (ADDR_W - BANK_W));
    @(negedge clk); op_done = 0; rd = 0;
    read(3, 1);
    // fresh erase resets toggles and timeout
    start(1, 2, 0);
    read(2, 0); read(2, 1);
    finish_op();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule